// File: doc/BRIEF.md
# Compressed Instruction Decoder (32-bit, quadrants 0-2)

This block takes one 16-bit compressed instruction word and, in the same cycle, turns it into a flat micro-op bundle that a 32-bit integer pipeline can execute. It works out which operation the word encodes and puts the immediate back together from the bits scattered across the word. It expands any three-bit register field to a full five-bit index, and it raises flags for illegal words, breakpoints and the compressed jump-to-self that a simulation harness uses as a stop signal.

The decoder has no state. It sits between fetch alignment and the main decoder's operand-select logic. When the word uses a register destination, a write enable is produced. A separate link flag tells the execute stage to write the address of the next instruction (PC+2) into the destination. Some encodings overlap, and a fixed priority order settles them. Words that belong only to wider register sizes, and floating-point or reserved slots, come out as illegal.

Top module: `cdec_top`

## Requirements
- R1: Bits [1:0] pick the quadrant and bits [15:13] pick the function inside it. Any word with bits [1:0]=11 is illegal. The op output numbers the operations 0 ILL, 1 ADDI4SPN, 2 LW, 3 SW, 4 NOP, 5 ADDI, 6 JAL, 7 LI, 8 ADDI16SP, 9 LUI, 10 SRLI, 11 SRAI, 12 ANDI, 13 SUB, 14 XOR, 15 OR, 16 AND, 17 J, 18 BEQZ, 19 BNEZ, 20 SLLI, 21 LWSP, 22 JR, 23 MV, 24 EBREAK, 25 JALR, 26 ADD, 27 SWSP. A three-bit register field f stands for register 8+f. Fields a form does not use read as zero.
- R2: The word 0x0000 is illegal. For every illegal word: op=0, illegal=1, rd_we=0, link=0, and rd, rs1, rs2 and imm are all zero.
- R3: Quadrant 0, function 000 adds a zero-extended offset to x2 and writes it to rd=8+inst[4:2]; rs1=2. The offset is built as imm[9:6]=inst[10:7], imm[5:4]=inst[12:11], imm[3]=inst[5], imm[2]=inst[6]. An offset of zero is illegal.
- R4: The word load and store (quadrant 0, functions 010 and 110) use base rs1=8+inst[9:7]. Their offset is uimm[6]=inst[5], uimm[5:3]=inst[12:10], uimm[2]=inst[6]. The load writes rd=8+inst[4:2], and the store reads rs2=8+inst[4:2]. The stack-relative load (quadrant 2, function 010) uses rs1=2 and rd=inst[11:7], with uimm[7:6]=inst[3:2], uimm[5]=inst[12], uimm[4:2]=inst[6:4]. The stack-relative store (function 110) uses rs1=2 and rs2=inst[6:2], with uimm[7:6]=inst[8:7], uimm[5:2]=inst[12:9].
- R5: In quadrant 1, function 011 with inst[11:7]=2 is the stack adjust. It wins over the upper-immediate load and gives rd=rs1=2. Its sign-extended immediate is imm[9]=inst[12], imm[8:7]=inst[4:3], imm[6]=inst[5], imm[5]=inst[2], imm[4]=inst[6].
- R6: The upper-immediate load puts inst[12] at bit 17 and sign-extends from there, with imm[16:12]=inst[6:2]. It is illegal when rd=0 or when the immediate is zero. The load-immediate (function 010) is illegal when rd=0, and otherwise gives rd=inst[11:7], rs1=0, imm sign-extended from inst[12],inst[6:2].
- R7: The exact word 0x0001 is NOP, with no write. Every other quadrant-1 function-000 word is ADDI with rd=rs1=inst[11:7] and a sign-extended six-bit immediate. A zero immediate is legal there.
- R8: The right-shift forms (0x8001 and 0x8401 under mask 0xFC03) and the left shift (mask 0xF003) are illegal when inst[12]=1. The left shift is also illegal when rs1=0. The shift amount is inst[6:2], zero-extended.
- R9: Branch-if-zero and branch-if-nonzero take rs1=8+inst[9:7] and a sign-extended offset with imm[8]=inst[12], imm[7:6]=inst[6:5], imm[5]=inst[2], imm[4:3]=inst[11:10], imm[2:1]=inst[4:3]. The jump forms take imm[11]=inst[12], imm[10]=inst[8], imm[9:8]=inst[10:9], imm[7]=inst[6], imm[6]=inst[7], imm[5]=inst[2], imm[4]=inst[11], imm[3:1]=inst[5:3].
- R10: Quadrant 2, function 100 is resolved in this order:
  - 0x9002 is EBREAK, with brk=1.
  - inst[12]=1 and inst[6:2]=0 is JALR.
  - inst[12]=1 otherwise is ADD.
  - inst[12]=0 and inst[6:2]=0 is JR.
  - inst[12]=0 otherwise is MV.
- R11: JAL and JALR drive rd=1, rd_we=1 and link=1, which means the destination takes PC+2. No other operation sets link.
- R12: halt is 1 for the word 0xA001 and for no other word, and that word still decodes as J with imm=0.
- R13: Function codes with no integer operation on 32-bit registers are illegal. This covers quadrant 0 functions 001/011/100/101/111, quadrant 2 functions 001/011/101/111, and quadrant 1 function 100 with inst[11:10]=11 and inst[12]=1.
- R14: Quadrant 1, function 100 with inst[11:10]=10 is ANDI. With inst[11:10]=11 and inst[12]=0, inst[6:5] selects 00 SUB, 01 XOR, 10 OR or 11 AND. These forms use rd=rs1=8+inst[9:7], and the register forms read rs2=8+inst[4:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 16 | Compressed instruction word |
| op | output | 5 | Operation number (see R1) |
| rd | output | 5 | Destination register index |
| rs1 | output | 5 | First source register index |
| rs2 | output | 5 | Second source register index |
| imm | output | 32 | Reassembled immediate, already extended |
| rd_we | output | 1 | Destination write enable |
| link | output | 1 | Destination takes PC+2 |
| illegal | output | 1 | Word is not a legal instruction |
| brk | output | 1 | Breakpoint requested |
| halt | output | 1 | Compressed jump-to-self seen |

## Verification
The hand-assembled table goes after the overlaps:
- A decoder that checks the upper-immediate load before the stack adjust would make x2 the target of a LUI.
- One that drops the 0x0001 check would report an ADDI that writes x0.
- One with the quadrant-2 order wrong would turn EBREAK into a JALR through x0, or turn every jump-register form into an ADD.

The scrambled immediates are checked one bit at a time for the jump, branch and stack-adjust forms, so a swapped bit pair shows up as a wrong offset. An exhaustive sweep of all 65536 words confirms three things: illegal words never enable a write, quadrant 3 never decodes, and halt and brk fire on exactly one word each.

// File: rtl/cdec_pkg.sv
package cdec_pkg;
  localparam int XLEN   = 32;
  localparam int REG_W  = 5;
  localparam int OP_W   = 5;
  localparam int WORD_W = 16;

  typedef enum logic [OP_W-1:0] {
    C_ILL      = 5'd0,
    C_ADDI4SPN = 5'd1,
    C_LW       = 5'd2,
    C_SW       = 5'd3,
    C_NOP      = 5'd4,
    C_ADDI     = 5'd5,
    C_JAL      = 5'd6,
    C_LI       = 5'd7,
    C_ADDI16SP = 5'd8,
    C_LUI      = 5'd9,
    C_SRLI     = 5'd10,
    C_SRAI     = 5'd11,
    C_ANDI     = 5'd12,
    C_SUB      = 5'd13,
    C_XOR      = 5'd14,
    C_OR       = 5'd15,
    C_AND      = 5'd16,
    C_J        = 5'd17,
    C_BEQZ     = 5'd18,
    C_BNEZ     = 5'd19,
    C_SLLI     = 5'd20,
    C_LWSP     = 5'd21,
    C_JR       = 5'd22,
    C_MV       = 5'd23,
    C_EBREAK   = 5'd24,
    C_JALR     = 5'd25,
    C_ADD      = 5'd26,
    C_SWSP     = 5'd27
  } cop_e;

  // every immediate layout, computed in parallel and selected by op
  typedef struct packed {
    logic [XLEN-1:0] spn;
    logic [XLEN-1:0] mem;
    logic [XLEN-1:0] six;
    logic [XLEN-1:0] upper;
    logic [XLEN-1:0] stk;
    logic [XLEN-1:0] jmp;
    logic [XLEN-1:0] br;
    logic [XLEN-1:0] ldsp;
    logic [XLEN-1:0] stsp;
    logic [XLEN-1:0] sh;
  } imm_set_t;
endpackage

// File: rtl/cdec_imm.sv
module cdec_imm
  import cdec_pkg::*;
(
  input  logic [WORD_W-1:0] w,
  output imm_set_t          imms
);
  always_comb begin
    imms.spn   = {{(XLEN-10){1'b0}}, w[10:7], w[12:11], w[5], w[6], 2'b00};
    imms.mem   = {{(XLEN-7){1'b0}}, w[5], w[12:10], w[6], 2'b00};
    imms.six   = {{(XLEN-5){w[12]}}, w[6:2]};
    imms.upper = {{(XLEN-17){w[12]}}, w[6:2], 12'h000};
    imms.stk   = {{(XLEN-9){w[12]}}, w[4:3], w[5], w[2], w[6], 4'h0};
    imms.jmp   = {{(XLEN-11){w[12]}}, w[8], w[10:9], w[6], w[7], w[2],
                  w[11], w[5:3], 1'b0};
    imms.br    = {{(XLEN-8){w[12]}}, w[6:5], w[2], w[11:10], w[4:3], 1'b0};
    imms.ldsp  = {{(XLEN-8){1'b0}}, w[3:2], w[12], w[6:4], 2'b00};
    imms.stsp  = {{(XLEN-8){1'b0}}, w[8:7], w[12:9], 2'b00};
    imms.sh    = {{(XLEN-5){1'b0}}, w[6:2]};
  end
endmodule

// File: rtl/cdec_regmap.sv
module cdec_regmap
  import cdec_pkg::*;
#(
  parameter int FIELD_W = 3
) (
  input  logic [FIELD_W-1:0] field,
  output logic [REG_W-1:0]   idx
);
  localparam int BASE = 8;
  assign idx = REG_W'(BASE) + REG_W'(field);
endmodule

// File: rtl/cdec_classify.sv
module cdec_classify
  import cdec_pkg::*;
(
  input  logic [WORD_W-1:0] w,
  output cop_e              op
);
  localparam logic [WORD_W-1:0] NOP_WORD = 16'h0001;
  localparam logic [WORD_W-1:0] BRK_WORD = 16'h9002;

  logic rd_nz, rs2_z, spn_nz, upper_nz;

  always_comb begin
    rd_nz    = |w[11:7];
    rs2_z    = ~|w[6:2];
    spn_nz   = |w[12:5];
    upper_nz = w[12] | (|w[6:2]);
  end

  always_comb begin
    op = C_ILL;
    case ({w[1:0], w[15:13]})
      5'b00_000: if (spn_nz) op = C_ADDI4SPN;
      5'b00_010: op = C_LW;
      5'b00_110: op = C_SW;
      5'b01_000: op = (w == NOP_WORD) ? C_NOP : C_ADDI;
      5'b01_001: op = C_JAL;
      5'b01_010: if (rd_nz) op = C_LI;
      5'b01_011: begin
        if (w[11:7] == 5'd2)        op = C_ADDI16SP;
        else if (rd_nz && upper_nz) op = C_LUI;
      end
      5'b01_100: begin
        case (w[11:10])
          2'b00: if (!w[12]) op = C_SRLI;
          2'b01: if (!w[12]) op = C_SRAI;
          2'b10: op = C_ANDI;
          default: begin
            if (!w[12]) begin
              case (w[6:5])
                2'b00:   op = C_SUB;
                2'b01:   op = C_XOR;
                2'b10:   op = C_OR;
                default: op = C_AND;
              endcase
            end
          end
        endcase
      end
      5'b01_101: op = C_J;
      5'b01_110: op = C_BEQZ;
      5'b01_111: op = C_BNEZ;
      5'b10_000: if (!w[12] && rd_nz) op = C_SLLI;
      5'b10_010: op = C_LWSP;
      5'b10_100: begin
        if (w == BRK_WORD) op = C_EBREAK;
        else if (w[12])    op = rs2_z ? C_JALR : C_ADD;
        else               op = rs2_z ? C_JR   : C_MV;
      end
      5'b10_110: op = C_SWSP;
      default:   op = C_ILL;
    endcase
  end

  always_comb begin
    if (!$isunknown(w)) begin
      assert_nop_first_R7: assert (w != NOP_WORD || op == C_NOP)
        else $error("exact NOP word not decoded as NOP");
      assert_stack_adjust_wins_R5: assert (!(w[1:0] == 2'b01 && w[15:13] == 3'b011
                                          && w[11:7] == 5'd2) || op == C_ADDI16SP)
        else $error("stack adjust lost to upper load");
      assert_shift_top_bit_R8: assert (!((op == C_SRLI) || (op == C_SRAI) || (op == C_SLLI))
                                       || !w[12])
        else $error("shift decoded with inst[12] set");
    end
  end
endmodule

// File: rtl/cdec_top.sv
module cdec_top
  import cdec_pkg::*;
(
  input  logic [15:0] instr,
  output logic [4:0]  op,
  output logic [4:0]  rd,
  output logic [4:0]  rs1,
  output logic [4:0]  rs2,
  output logic [31:0] imm,
  output logic        rd_we,
  output logic        link,
  output logic        illegal,
  output logic        brk,
  output logic        halt
);
  localparam int NPRIME = 2;
  localparam logic [REG_W-1:0] SP_IDX = REG_W'(2);
  localparam logic [REG_W-1:0] RA_IDX = REG_W'(1);

  cop_e                 kind;
  imm_set_t             imms;
  logic [REG_W-1:0]     prime [NPRIME];
  logic [REG_W-1:0]     full_a, full_b;

  cdec_classify u_class (.w(instr), .op(kind));
  cdec_imm      u_imm   (.w(instr), .imms(imms));

  // prime[0] from inst[9:7], prime[1] from inst[4:2]
  for (genvar g = 0; g < NPRIME; g++) begin : g_prime
    localparam int LSB = (g == 0) ? 7 : 2;
    cdec_regmap #(.FIELD_W(3)) u_map (
      .field(instr[LSB+2:LSB]),
      .idx  (prime[g])
    );
  end

  assign full_a = instr[11:7];
  assign full_b = instr[6:2];

  always_comb begin
    rd    = '0;
    rs1   = '0;
    rs2   = '0;
    imm   = '0;
    rd_we = 1'b0;
    link  = 1'b0;
    case (kind)
      C_ADDI4SPN: begin rd = prime[1]; rs1 = SP_IDX; imm = imms.spn; rd_we = 1'b1; end
      C_LW:       begin rd = prime[1]; rs1 = prime[0]; imm = imms.mem; rd_we = 1'b1; end
      C_SW:       begin rs1 = prime[0]; rs2 = prime[1]; imm = imms.mem; end
      C_ADDI:     begin rd = full_a; rs1 = full_a; imm = imms.six; rd_we = 1'b1; end
      C_JAL:      begin rd = RA_IDX; imm = imms.jmp; rd_we = 1'b1; link = 1'b1; end
      C_LI:       begin rd = full_a; imm = imms.six; rd_we = 1'b1; end
      C_ADDI16SP: begin rd = SP_IDX; rs1 = SP_IDX; imm = imms.stk; rd_we = 1'b1; end
      C_LUI:      begin rd = full_a; imm = imms.upper; rd_we = 1'b1; end
      C_SRLI, C_SRAI: begin
        rd = prime[0]; rs1 = prime[0]; imm = imms.sh; rd_we = 1'b1;
      end
      C_ANDI:     begin rd = prime[0]; rs1 = prime[0]; imm = imms.six; rd_we = 1'b1; end
      C_SUB, C_XOR, C_OR, C_AND: begin
        rd = prime[0]; rs1 = prime[0]; rs2 = prime[1]; rd_we = 1'b1;
      end
      C_J:        imm = imms.jmp;
      C_BEQZ, C_BNEZ: begin rs1 = prime[0]; imm = imms.br; end
      C_SLLI:     begin rd = full_a; rs1 = full_a; imm = imms.sh; rd_we = 1'b1; end
      C_LWSP:     begin rd = full_a; rs1 = SP_IDX; imm = imms.ldsp; rd_we = 1'b1; end
      C_JR:       rs1 = full_a;
      C_MV:       begin rd = full_a; rs2 = full_b; rd_we = 1'b1; end
      C_JALR:     begin rd = RA_IDX; rs1 = full_a; rd_we = 1'b1; link = 1'b1; end
      C_ADD:      begin rd = full_a; rs1 = full_a; rs2 = full_b; rd_we = 1'b1; end
      C_SWSP:     begin rs1 = SP_IDX; rs2 = full_b; imm = imms.stsp; end
      default:    ;
    endcase
  end

  assign op      = kind;
  assign illegal = (kind == C_ILL);
  assign brk     = (kind == C_EBREAK);
  assign halt    = (kind == C_J) && (imms.jmp == '0);

  always_comb begin
    if (!$isunknown(instr)) begin
      assert_illegal_quiet_R2: assert (!illegal || (!rd_we && !link && rd == '0 &&
                                        rs1 == '0 && rs2 == '0 && imm == '0))
        else $error("illegal word left a field or enable active");
      assert_quad3_illegal_R1: assert (instr[1:0] != 2'b11 || illegal)
        else $error("uncompressed quadrant decoded");
      assert_halt_word_R12: assert (!halt || instr == 16'hA001)
        else $error("halt on wrong word");
      assert_link_ra_R11: assert (!link || (rd == 5'd1 && rd_we))
        else $error("link without x1 write");
      assert_brk_word_R10: assert (!brk || instr == 16'h9002)
        else $error("breakpoint on wrong word");
    end
  end
endmodule

// File: tb/tb_cdec_top.sv
module tb_cdec_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 58;

  typedef struct packed {
    logic [15:0] w;
    logic [4:0]  op;
    logic [4:0]  rd;
    logic [4:0]  rs1;
    logic [4:0]  rs2;
    logic [31:0] imm;
    logic        we;
    logic        lk;
    logic        ill;
    logic        bk;
    logic        hl;
    logic [3:0]  req;
  } vec_t;

  // each row: word, op, rd, rs1, rs2, imm, we, link, illegal, brk, halt, requirement
  localparam vec_t VECS [NV] = '{
    '{16'h1044, 5'd1,  5'd9,  5'd2,  5'd0,  32'h24,       1'b1,1'b0,1'b0,1'b0,1'b0, 4'd3},  // R3
    '{16'h07BC, 5'd1,  5'd15, 5'd2,  5'd0,  32'h3C8,      1'b1,1'b0,1'b0,1'b0,1'b0, 4'd3},  // R3
    '{16'h0000, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b0,1'b0,1'b1,1'b0,1'b0, 4'd2},  // R2
    '{16'h0004, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b0,1'b0,1'b1,1'b0,1'b0, 4'd3},  // R3 zero offset
    '{16'h5D6C, 5'd2,  5'd11, 5'd10, 5'd0,  32'h7C,       1'b1,1'b0,1'b0,1'b0,1'b0, 4'd4},  // R4
    '{16'hC054, 5'd3,  5'd0,  5'd8,  5'd13, 32'h4,        1'b0,1'b0,1'b0,1'b0,1'b0, 4'd4},  // R4
    '{16'h0001, 5'd4,  5'd0,  5'd0,  5'd0,  32'h0,        1'b0,1'b0,1'b0,1'b0,1'b0, 4'd7},  // R7
    '{16'h12FD, 5'd5,  5'd5,  5'd5,  5'd0,  32'hFFFFFFFF, 1'b1,1'b0,1'b0,1'b0,1'b0, 4'd7},  // R7
    '{16'h0181, 5'd5,  5'd3,  5'd3,  5'd0,  32'h0,        1'b1,1'b0,1'b0,1'b0,1'b0, 4'd7},  // R7 zero imm legal
    '{16'h2801, 5'd6,  5'd1,  5'd0,  5'd0,  32'h10,       1'b1,1'b1,1'b0,1'b0,1'b0, 4'd11}, // R11
    '{16'h3FFD, 5'd6,  5'd1,  5'd0,  5'd0,  32'hFFFFFFFE, 1'b1,1'b1,1'b0,1'b0,1'b0, 4'd11}, // R11
    '{16'hA005, 5'd17, 5'd0,  5'd0,  5'd0,  32'h20,       1'b0,1'b0,1'b0,1'b0,1'b0, 4'd9},  // R9
    '{16'hA081, 5'd17, 5'd0,  5'd0,  5'd0,  32'h40,       1'b0,1'b0,1'b0,1'b0,1'b0, 4'd9},  // R9
    '{16'hA101, 5'd17, 5'd0,  5'd0,  5'd0,  32'h400,      1'b0,1'b0,1'b0,1'b0,1'b0, 4'd9},  // R9
    '{16'hA041, 5'd17, 5'd0,  5'd0,  5'd0,  32'h80,       1'b0,1'b0,1'b0,1'b0,1'b0, 4'd9},  // R9
    '{16'hA001, 5'd17, 5'd0,  5'd0,  5'd0,  32'h0,        1'b0,1'b0,1'b0,1'b0,1'b1, 4'd12}, // R12
    '{16'h4515, 5'd7,  5'd10, 5'd0,  5'd0,  32'h5,        1'b1,1'b0,1'b0,1'b0,1'b0, 4'd6},  // R6
    '{16'h4015, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b0,1'b0,1'b1,1'b0,1'b0, 4'd6},  // R6
    '{16'h717D, 5'd8,  5'd2,  5'd2,  5'd0,  32'hFFFFFFF0, 1'b1,1'b0,1'b0,1'b0,1'b0, 4'd5},  // R5
    '{16'h6141, 5'd8,  5'd2,  5'd2,  5'd0,  32'h10,       1'b1,1'b0,1'b0,1'b0,1'b0, 4'd5},  // R5
    '{16'h6121, 5'd8,  5'd2,  5'd2,  5'd0,  32'h40,       1'b1,1'b0,1'b0,1'b0,1'b0, 4'd5},  // R5
    '{16'h6109, 5'd8,  5'd2,  5'd2,  5'd0,  32'h80,       1'b1,1'b0,1'b0,1'b0,1'b0, 4'd5},  // R5
    '{16'h6285, 5'd9,  5'd5,  5'd0,  5'd0,  32'h1000,     1'b1,1'b0,1'b0,1'b0,1'b0, 4'd6},  // R6
    '{16'h7281, 5'd9,  5'd5,  5'd0,  5'd0,  32'hFFFE0000, 1'b1,1'b0,1'b0,1'b0,1'b0, 4'd6},  // R6
    '{16'h6005, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b0,1'b0,1'b1,1'b0,1'b0, 4'd6},  // R6 rd=0
    '{16'h6281, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b0,1'b0,1'b1,1'b0,1'b0, 4'd6},  // R6 zero
    '{16'h808D, 5'd10, 5'd9,  5'd9,  5'd0,  32'h3,        1'b1,1'b0,1'b0,1'b0,1'b0, 4'd8},  // R8
    '{16'h908D, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b0,1'b0,1'b1,1'b0,1'b0, 4'd8},  // R8
    '{16'h87FD, 5'd11, 5'd15, 5'd15, 5'd0,  32'h1F,       1'b1,1'b0,1'b0,1'b0,1'b0, 4'd8},  // R8
    '{16'h97FD, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b0,1'b0,1'b1,1'b0,1'b0, 4'd8},  // R8
    '{16'h9879, 5'd12, 5'd8,  5'd8,  5'd0,  32'hFFFFFFFE, 1'b1,1'b0,1'b0,1'b0,1'b0, 4'd14}, // R14
    '{16'h8D0D, 5'd13, 5'd10, 5'd10, 5'd11, 32'h0,        1'b1,1'b0,1'b0,1'b0,1'b0, 4'd14}, // R14
    '{16'h8C25, 5'd14, 5'd8,  5'd8,  5'd9,  32'h0,        1'b1,1'b0,1'b0,1'b0,1'b0, 4'd14}, // R14
    '{16'h8DC9, 5'd15, 5'd11, 5'd11, 5'd10, 32'h0,        1'b1,1'b0,1'b0,1'b0,1'b0, 4'd14}, // R14
    '{16'h8E7D, 5'd16, 5'd12, 5'd12, 5'd15, 32'h0,        1'b1,1'b0,1'b0,1'b0,1'b0, 4'd14}, // R14
    '{16'h9D0D, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b0,1'b0,1'b1,1'b0,1'b0, 4'd13}, // R13
    '{16'hDCFD, 5'd18, 5'd0,  5'd9,  5'd0,  32'hFFFFFFFE, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd9},  // R9
    '{16'hE401, 5'd19, 5'd0,  5'd8,  5'd0,  32'h8,        1'b0,1'b0,1'b0,1'b0,1'b0, 4'd9},  // R9
    '{16'hE005, 5'd19, 5'd0,  5'd8,  5'd0,  32'h20,       1'b0,1'b0,1'b0,1'b0,1'b0, 4'd9},  // R9
    '{16'hE021, 5'd19, 5'd0,  5'd8,  5'd0,  32'h40,       1'b0,1'b0,1'b0,1'b0,1'b0, 4'd9},  // R9
    '{16'h0392, 5'd20, 5'd7,  5'd7,  5'd0,  32'h4,        1'b1,1'b0,1'b0,1'b0,1'b0, 4'd8},  // R8
    '{16'h0012, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b0,1'b0,1'b1,1'b0,1'b0, 4'd8},  // R8 rs1=0
    '{16'h1392, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b0,1'b0,1'b1,1'b0,1'b0, 4'd8},  // R8 bit12
    '{16'h527E, 5'd21, 5'd4,  5'd2,  5'd0,  32'hFC,       1'b1,1'b0,1'b0,1'b0,1'b0, 4'd4},  // R4
    '{16'h4216, 5'd21, 5'd4,  5'd2,  5'd0,  32'h44,       1'b1,1'b0,1'b0,1'b0,1'b0, 4'd4},  // R4
    '{16'hC326, 5'd27, 5'd0,  5'd2,  5'd9,  32'h84,       1'b0,1'b0,1'b0,1'b0,1'b0, 4'd4},  // R4
    '{16'h2082, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b0,1'b0,1'b1,1'b0,1'b0, 4'd13}, // R13
    '{16'hE002, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b0,1'b0,1'b1,1'b0,1'b0, 4'd13}, // R13
    '{16'h2000, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b0,1'b0,1'b1,1'b0,1'b0, 4'd13}, // R13
    '{16'h8000, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b0,1'b0,1'b1,1'b0,1'b0, 4'd13}, // R13
    '{16'h0003, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b0,1'b0,1'b1,1'b0,1'b0, 4'd1},  // R1
    '{16'hFFFF, 5'd0,  5'd0,  5'd0,  5'd0,  32'h0,        1'b0,1'b0,1'b1,1'b0,1'b0, 4'd1},  // R1
    '{16'h9002, 5'd24, 5'd0,  5'd0,  5'd0,  32'h0,        1'b0,1'b0,1'b0,1'b1,1'b0, 4'd10}, // R10
    '{16'h9282, 5'd25, 5'd1,  5'd5,  5'd0,  32'h0,        1'b1,1'b1,1'b0,1'b0,1'b0, 4'd10}, // R10
    '{16'h929A, 5'd26, 5'd5,  5'd5,  5'd6,  32'h0,        1'b1,1'b0,1'b0,1'b0,1'b0, 4'd10}, // R10
    '{16'h8282, 5'd22, 5'd0,  5'd5,  5'd0,  32'h0,        1'b0,1'b0,1'b0,1'b0,1'b0, 4'd10}, // R10
    '{16'h829A, 5'd23, 5'd5,  5'd0,  5'd6,  32'h0,        1'b1,1'b0,1'b0,1'b0,1'b0, 4'd10}, // R10
    '{16'hB001, 5'd17, 5'd0,  5'd0,  5'd0,  32'hFFFFF800, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd12}  // R12 not halt
  };

  logic        clk;
  logic [15:0] instr;
  logic [4:0]  op, rd, rs1, rs2;
  logic [31:0] imm;
  logic        rd_we, link, illegal, brk, halt;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;

  cdec_top dut (
    .instr(instr), .op(op), .rd(rd), .rs1(rs1), .rs2(rs2), .imm(imm),
    .rd_we(rd_we), .link(link), .illegal(illegal), .brk(brk), .halt(halt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic vec_t observed(input logic [15:0] w);
    vec_t v;
    v = '{w, op, rd, rs1, rs2, imm, rd_we, link, illegal, brk, halt, 4'd0};
    return v;
  endfunction

  task automatic check_vec(input vec_t exp);
    vec_t act;
    instr = exp.w;
    #1;
    act = observed(exp.w);
    act.req = exp.req;
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL R%0d word=%h actual op=%0d rd=%0d rs1=%0d rs2=%0d imm=%h we=%b lk=%b ill=%b bk=%b hl=%b expected op=%0d rd=%0d rs1=%0d rs2=%0d imm=%h we=%b lk=%b ill=%b bk=%b hl=%b",
               exp.req, exp.w, act.op, act.rd, act.rs1, act.rs2, act.imm, act.we, act.lk,
               act.ill, act.bk, act.hl, exp.op, exp.rd, exp.rs1, exp.rs2, exp.imm, exp.we,
               exp.lk, exp.ill, exp.bk, exp.hl);
    end
  endtask

  initial begin
    instr = 16'h0000;
    @(negedge clk);
    // R2: power-up word (all zero) decodes as illegal with nothing enabled
    n_checks++;
    if (illegal !== 1'b1 || rd_we !== 1'b0 || op !== 5'd0) begin
      n_errors++;
      $display("FAIL R2 initial word actual ill=%b we=%b op=%0d expected ill=1 we=0 op=0",
               illegal, rd_we, op);
    end

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check_vec(VECS[i]);
    end

    // exhaustive sweep: R2 quiet illegal, R1 quadrant 3, R12 halt word, R10 brk word
    for (int k = 0; k < 65536; k++) begin
      logic exp_q3, exp_h, exp_b, bad;
      instr = k[15:0];
      #1;
      exp_q3 = (k[1:0] == 2'b11);
      exp_h  = (k == 32'hA001);
      exp_b  = (k == 32'h9002);
      bad = (illegal && (rd_we || link || imm != 32'h0)) ||
            (exp_q3 && !illegal) || (halt !== exp_h) || (brk !== exp_b);
      n_checks++;
      if (bad) begin
        n_errors++;
        $display("FAIL R2/R1/R12/R10 sweep word=%h actual ill=%b we=%b lk=%b hl=%b bk=%b expected quad3=%b hl=%b bk=%b",
                 k[15:0], illegal, rd_we, link, halt, brk, exp_q3, exp_h, exp_b);
      end
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule